// File: doc/BRIEF.md
# Host Data FIFO with Threshold-Driven DMA Requests

This block buffers data between a processor data port and a card that moves one byte at a time. Storage is a ring of 32 halfwords. When receiving, card bytes are paired into halfwords before they are stored. When transmitting, halfwords are split back into bytes. A byte counter and a block counter follow the progress of a multi-block transfer. Both counters work with odd block lengths: the last byte of an odd-length block occupies an entry by itself.

Two programmable levels decide when the buffer needs service. In the receive direction the trigger is a fill count above the almost-full level. In the transmit direction the trigger is a fill count below the almost-empty level. For each direction, an enable bit chooses how the need for service is signalled: either a DMA request line or a status flag that software polls. After the last byte of the last block, the transfer ends and a sticky end-of-transfer flag is raised.

A data-transfer command (`cmd_start`) clears the ring, latches the direction and reloads the counters. The card side uses a byte valid/ready handshake in each direction.

Top module: `xfer_fifo`

## Requirements
- R1: The ring holds 32 halfword entries. Its read and write indices wrap modulo 32, and entries come out in the order they went in, including across the wrap.
- R2: A processor write while the ring holds 32 entries is ignored, and `fill_level` stays 32. Processor writes are also ignored while a receive transfer is active.
- R3: Receive service is needed when a receive transfer is active (or the ring is not empty) and `fill_level` is strictly greater than the almost-full level. If receive DMA is enabled, `dma_rx_req` is 1 and `status[10]` is 0. Otherwise `status[10]` is 1 and `dma_rx_req` is 0.
- R4: Transmit service is needed when a transmit transfer is active (or the ring is not empty) and `fill_level` is strictly less than the almost-empty level. If transmit DMA is enabled, `dma_tx_req` is 1 and `status[11]` is 0. Otherwise `status[11]` is 1 and `dma_tx_req` is 0.
- R5: With no transfer active and an empty ring, `status[11:10]` and both DMA requests are 0.
- R6: `cfg_we` loads the receive DMA enable, the almost-full level, the transmit DMA enable and the almost-empty level. After reset the almost-full level is 31, the almost-empty level is 0 and both DMA enables are 0. After reset `status` is 0, `fill_level` is 0, and `bytes_left` and `blocks_left` are 1.
- R7: `blen_we` sets the block length to `len_wdata`+1 bytes and also loads `bytes_left` with that value. `nblk_we` sets the block count to `len_wdata`+1, loads `blocks_left` with it, and reloads `bytes_left` from the block length.
- R8: Each entry carries the earlier card byte in bits 7:0 and the later byte in bits 15:8. When only one byte of a block remains, that byte forms an entry alone, with bits 15:8 equal to 0. The transmit side sends bytes in the same order.
- R9: `card_rx_ready` is 0 once `fill_level` exceeds the almost-full level, which stops receive filling. `card_tx_valid` is 0 while the ring is empty.
- R10: When `bytes_left` reaches zero, `blocks_left` decrements and `bytes_left` reloads. After the last block, `blocks_left` reloads, `xfer_active` falls and `status[3]` is set. `status[3]` stays set until `eot_clr` is pulsed.
- R11: A processor read of an empty ring returns the head entry and moves neither index.
- R12: `cmd_start` empties the ring and resets both indices. It latches `cmd_rx` as the direction (1 means card to processor) and reloads both counters.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| cfg_we | input | 1 | Load buffer configuration |
| cfg_rx_dma | input | 1 | Receive DMA enable |
| cfg_af_lvl | input | 5 | Almost-full level |
| cfg_tx_dma | input | 1 | Transmit DMA enable |
| cfg_ae_lvl | input | 5 | Almost-empty level |
| blen_we | input | 1 | Load block length |
| nblk_we | input | 1 | Load block count |
| len_wdata | input | 11 | Length or count value minus one |
| cmd_start | input | 1 | New data-transfer command |
| cmd_rx | input | 1 | Direction for the command, 1 means receive |
| cpu_wr | input | 1 | Processor data write |
| cpu_wdata | input | 16 | Processor write data |
| cpu_rd | input | 1 | Processor data read (pops the entry) |
| cpu_rdata | output | 16 | Head entry |
| eot_clr | input | 1 | Clear end-of-transfer flag |
| status | output | 16 | Bit 3 end of transfer, bit 10 receive level, bit 11 transmit level |
| dma_rx_req | output | 1 | Receive DMA request |
| dma_tx_req | output | 1 | Transmit DMA request |
| xfer_active | output | 1 | Transfer in progress |
| fill_level | output | 6 | Entries held |
| bytes_left | output | 12 | Bytes left in the current block |
| blocks_left | output | 12 | Blocks left |
| card_rx_valid | input | 1 | Card byte available |
| card_rx_data | input | 8 | Card byte |
| card_rx_ready | output | 1 | Block accepts a card byte |
| card_tx_valid | output | 1 | Byte for the card available |
| card_tx_data | output | 8 | Byte for the card |
| card_tx_ready | input | 1 | Card accepts the byte |

## Verification
The bench targets odd-length blocks. A design that always pairs bytes would merge the last byte of one block with the first byte of the next, and the last entry of each block would come out wrong. The threshold comparisons are probed exactly at the boundary, with fill equal to the level, one above and one below. An off-by-one there would raise or drop a request one entry early and would also stop receive filling one entry early. The bench also checks that a write to a full ring is dropped and that a read of an empty ring moves no index; mishandling either would corrupt the count or repeat or skip entries across the index wrap. Finally, it checks that the DMA enable moves the indication between the request line and the status flag, never driving both.

// File: rtl/xfer_pkg.sv
package xfer_pkg;
  localparam int BYTE_W = 8;
  localparam int WORD_W = 2 * BYTE_W;

  // Build a ring entry: the earlier byte sits low; a lone byte has zero above it.
  function automatic logic [WORD_W-1:0] pack_entry(input logic [BYTE_W-1:0] early,
                                                   input logic [BYTE_W-1:0] late,
                                                   input logic              pair);
    pack_entry = pair ? {late, early} : {{BYTE_W{1'b0}}, early};
  endfunction

  // Select the byte of an entry sent in the given half (0 = low).
  function automatic logic [BYTE_W-1:0] pick_byte(input logic [WORD_W-1:0] entry,
                                                  input logic              upper);
    pick_byte = upper ? entry[WORD_W-1:BYTE_W] : entry[BYTE_W-1:0];
  endfunction

  // Half pointer after one byte: back to low when the entry closes.
  function automatic logic next_half(input logic upper, input logic last_in_block);
    next_half = !(upper || last_in_block);
  endfunction
endpackage

// File: rtl/xfer_ring.sv
module xfer_ring #(
  parameter int DEPTH = 32,
  parameter int WIDTH = 16,
  localparam int PTR_W = $clog2(DEPTH),
  localparam int CNT_W = PTR_W + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             push,
  input  logic [WIDTH-1:0] push_data,
  input  logic             pop,
  output logic [WIDTH-1:0] head,
  output logic [CNT_W-1:0] count,
  output logic             full,
  output logic             empty
);
  logic [WIDTH-1:0] mem [DEPTH];
  logic [PTR_W-1:0] rd_ptr_q, wr_ptr_q;
  logic [CNT_W-1:0] count_q;
  logic             do_push, do_pop;

  assign full    = (count_q == CNT_W'(DEPTH));
  assign empty   = (count_q == '0);
  assign do_push = push && !full;
  assign do_pop  = pop && !empty;
  assign head    = mem[rd_ptr_q];
  assign count   = count_q;

  always_ff @(posedge clk) begin
    if (do_push && !clear) mem[wr_ptr_q] <= push_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_ptr_q <= '0;
      wr_ptr_q <= '0;
      count_q  <= '0;
    end else if (clear) begin
      rd_ptr_q <= '0;
      wr_ptr_q <= '0;
      count_q  <= '0;
    end else begin
      if (do_push) wr_ptr_q <= wr_ptr_q + 1'b1;
      if (do_pop)  rd_ptr_q <= rd_ptr_q + 1'b1;
      case ({do_push, do_pop})
        2'b10:   count_q <= count_q + 1'b1;
        2'b01:   count_q <= count_q - 1'b1;
        default: count_q <= count_q;
      endcase
    end
  end

  // R1
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    count_q <= CNT_W'(DEPTH));
  // R2
  full_write_dropped_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (push && full && !pop && !clear) |=> (count_q == CNT_W'(DEPTH)));
  // R11
  empty_read_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && empty && !push && !clear) |=> ($stable(rd_ptr_q) && count_q == '0));
endmodule

// File: rtl/xfer_counters.sv
module xfer_counters #(
  parameter int LEN_W = 11,
  localparam int CW = LEN_W + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             blen_we,
  input  logic             nblk_we,
  input  logic [LEN_W-1:0] wdata,
  input  logic             reload,
  input  logic             byte_step,
  output logic [CW-1:0]    bytes_left,
  output logic [CW-1:0]    blocks_left,
  output logic             last_byte,
  output logic             block_done,
  output logic             xfer_done
);
  logic [CW-1:0] blen_q, nblk_q, bytes_q, blocks_q;
  logic [CW-1:0] wval;

  assign wval        = {1'b0, wdata} + 1'b1;
  assign last_byte   = (bytes_q == CW'(1));
  assign block_done  = byte_step && last_byte;
  assign xfer_done   = block_done && (blocks_q == CW'(1));
  assign bytes_left  = bytes_q;
  assign blocks_left = blocks_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      blen_q   <= CW'(1);
      nblk_q   <= CW'(1);
      bytes_q  <= CW'(1);
      blocks_q <= CW'(1);
    end else if (blen_we) begin
      blen_q  <= wval;
      bytes_q <= wval;
    end else if (nblk_we) begin
      nblk_q   <= wval;
      blocks_q <= wval;
      bytes_q  <= blen_q;
    end else if (reload) begin
      bytes_q  <= blen_q;
      blocks_q <= nblk_q;
    end else if (byte_step) begin
      if (last_byte) begin
        bytes_q  <= blen_q;
        blocks_q <= (blocks_q == CW'(1)) ? nblk_q : blocks_q - 1'b1;
      end else begin
        bytes_q <= bytes_q - 1'b1;
      end
    end
  end

  // R10
  block_reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (block_done && !blen_we && !nblk_we && !reload) |=> (bytes_q == blen_q));
  // R7
  count_write_reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (nblk_we && !blen_we) |=> (bytes_q == blen_q && blocks_q == nblk_q));
endmodule

// File: rtl/xfer_thresh.sv
module xfer_thresh #(
  parameter int LVL_W = 5
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [LVL_W:0] fill,
  input  logic [LVL_W-1:0] af_lvl,
  input  logic [LVL_W-1:0] ae_lvl,
  input  logic           rx_dma_en,
  input  logic           tx_dma_en,
  input  logic           active,
  input  logic           dir_rx,
  output logic           rx_req,
  output logic           tx_req,
  output logic           rx_flag,
  output logic           tx_flag
);
  logic live, rx_hit, tx_hit;

  assign live   = active || (fill != '0);
  assign rx_hit = live && dir_rx && (fill > {1'b0, af_lvl});
  assign tx_hit = live && !dir_rx && (fill < {1'b0, ae_lvl});

  assign rx_req  = rx_hit && rx_dma_en;
  assign rx_flag = rx_hit && !rx_dma_en;
  assign tx_req  = tx_hit && tx_dma_en;
  assign tx_flag = tx_hit && !tx_dma_en;

  // R3
  rx_route_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(rx_req && rx_flag));
  // R4
  tx_route_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(tx_req && tx_flag));
  // R5
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!active && fill == '0) |-> !(rx_req || tx_req || rx_flag || tx_flag));
endmodule

// File: rtl/xfer_fifo.sv
module xfer_fifo #(
  parameter int DEPTH = 32,
  parameter int LEN_W = 11,
  localparam int LVL_W = $clog2(DEPTH),
  localparam int WW = xfer_pkg::WORD_W,
  localparam int BW = xfer_pkg::BYTE_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_we,
  input  logic             cfg_rx_dma,
  input  logic [LVL_W-1:0] cfg_af_lvl,
  input  logic             cfg_tx_dma,
  input  logic [LVL_W-1:0] cfg_ae_lvl,
  input  logic             blen_we,
  input  logic             nblk_we,
  input  logic [LEN_W-1:0] len_wdata,
  input  logic             cmd_start,
  input  logic             cmd_rx,
  input  logic             cpu_wr,
  input  logic [WW-1:0]    cpu_wdata,
  input  logic             cpu_rd,
  output logic [WW-1:0]    cpu_rdata,
  input  logic             eot_clr,
  output logic [15:0]      status,
  output logic             dma_rx_req,
  output logic             dma_tx_req,
  output logic             xfer_active,
  output logic [LVL_W:0]   fill_level,
  output logic [LEN_W:0]   bytes_left,
  output logic [LEN_W:0]   blocks_left,
  input  logic             card_rx_valid,
  input  logic [BW-1:0]    card_rx_data,
  output logic             card_rx_ready,
  output logic             card_tx_valid,
  output logic [BW-1:0]    card_tx_data,
  input  logic             card_tx_ready
);
  import xfer_pkg::*;

  // configuration and control state
  logic             rx_dma_q, tx_dma_q;
  logic [LVL_W-1:0] af_q, ae_q;
  logic             active_q, dir_rx_q, upper_q, eot_q;
  logic [BW-1:0]    early_q;

  // named internal events
  logic          rx_take, tx_take, byte_step;
  logic          rx_push, tx_pop, cpu_push, cpu_pop;
  logic          ring_push, ring_pop;
  logic [WW-1:0] push_word, head;
  logic          ring_full, ring_empty;
  logic          last_byte, block_done, xfer_done;
  logic          rx_flag, tx_flag;

  assign card_rx_ready = active_q && dir_rx_q && (fill_level <= {1'b0, af_q});
  assign rx_take       = card_rx_valid && card_rx_ready;
  assign card_tx_valid = active_q && !dir_rx_q && !ring_empty;
  assign card_tx_data  = pick_byte(head, upper_q);
  assign tx_take       = card_tx_valid && card_tx_ready;
  assign byte_step     = rx_take || tx_take;

  assign rx_push   = rx_take && (upper_q || last_byte);
  assign tx_pop    = tx_take && (upper_q || last_byte);
  assign cpu_push  = cpu_wr && !(active_q && dir_rx_q);
  assign cpu_pop   = cpu_rd && !(active_q && !dir_rx_q);
  assign ring_push = rx_push || cpu_push;
  assign ring_pop  = tx_pop || cpu_pop;
  assign push_word = rx_push ? pack_entry(upper_q ? early_q : card_rx_data, card_rx_data, upper_q)
                             : cpu_wdata;
  assign cpu_rdata = head;

  xfer_ring #(.DEPTH(DEPTH), .WIDTH(WW)) u_ring (
    .clk(clk), .rst_n(rst_n), .clear(cmd_start),
    .push(ring_push), .push_data(push_word), .pop(ring_pop),
    .head(head), .count(fill_level), .full(ring_full), .empty(ring_empty)
  );

  xfer_counters #(.LEN_W(LEN_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .blen_we(blen_we), .nblk_we(nblk_we),
    .wdata(len_wdata), .reload(cmd_start), .byte_step(byte_step),
    .bytes_left(bytes_left), .blocks_left(blocks_left),
    .last_byte(last_byte), .block_done(block_done), .xfer_done(xfer_done)
  );

  xfer_thresh #(.LVL_W(LVL_W)) u_thr (
    .clk(clk), .rst_n(rst_n), .fill(fill_level), .af_lvl(af_q), .ae_lvl(ae_q),
    .rx_dma_en(rx_dma_q), .tx_dma_en(tx_dma_q), .active(active_q), .dir_rx(dir_rx_q),
    .rx_req(dma_rx_req), .tx_req(dma_tx_req), .rx_flag(rx_flag), .tx_flag(tx_flag)
  );

  always_comb begin
    status     = '0;
    status[3]  = eot_q;
    status[10] = rx_flag;
    status[11] = tx_flag;
  end
  assign xfer_active = active_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_dma_q <= 1'b0;
      tx_dma_q <= 1'b0;
      af_q     <= '1;
      ae_q     <= '0;
      active_q <= 1'b0;
      dir_rx_q <= 1'b0;
      upper_q  <= 1'b0;
      early_q  <= '0;
      eot_q    <= 1'b0;
    end else begin
      if (cfg_we) begin
        rx_dma_q <= cfg_rx_dma;
        tx_dma_q <= cfg_tx_dma;
        af_q     <= cfg_af_lvl;
        ae_q     <= cfg_ae_lvl;
      end
      if (cmd_start) begin
        active_q <= 1'b1;
        dir_rx_q <= cmd_rx;
        upper_q  <= 1'b0;
      end else begin
        if (xfer_done) active_q <= 1'b0;
        if (byte_step) upper_q <= next_half(upper_q, last_byte);
        if (rx_take && !upper_q) early_q <= card_rx_data;
      end
      if (xfer_done && !cmd_start) eot_q <= 1'b1;
      else if (eot_clr)            eot_q <= 1'b0;
    end
  end

  // R9
  rx_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_take && !cmd_start) |=> (fill_level <= {1'b0, af_q} + 1'b1));
  // R9
  tx_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    card_tx_valid |-> !ring_empty);
  // R10
  end_of_xfer_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_done && !cmd_start) |=> (!active_q && status[3]));
  // R3
  one_request_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({dma_rx_req, dma_tx_req}));
  // R12
  start_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_start |=> (fill_level == '0 && active_q && dir_rx_q == $past(cmd_rx)));
endmodule

// File: tb/xfer_fifo_test.sv
module xfer_fifo_test;
  logic clk = 0, rst_n = 0;
  logic cfg_we = 0, cfg_rx_dma = 0, cfg_tx_dma = 0;
  logic [4:0] cfg_af_lvl = 5'd31, cfg_ae_lvl = 0;
  logic blen_we = 0, nblk_we = 0;
  logic [10:0] len_wdata = 0;
  logic cmd_start = 0, cmd_rx = 0, cpu_wr = 0, cpu_rd = 0, eot_clr = 0;
  logic [15:0] cpu_wdata = 0, cpu_rdata, status;
  logic dma_rx_req, dma_tx_req, xfer_active;
  logic [5:0] fill_level;
  logic [11:0] bytes_left, blocks_left;
  logic card_rx_valid = 0, card_rx_ready, card_tx_valid, card_tx_ready = 0;
  logic [7:0] card_rx_data = 0, card_tx_data;
  int n_tests = 0, n_fail = 0;

  always #5 clk = ~clk;

  xfer_fifo uut (.*);

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic report();
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  endtask

  task automatic cfg(input logic rxd, input logic [4:0] af, input logic txd, input logic [4:0] ae);
    cfg_we = 1; cfg_rx_dma = rxd; cfg_af_lvl = af; cfg_tx_dma = txd; cfg_ae_lvl = ae;
    @(negedge clk); cfg_we = 0;
  endtask
  task automatic set_blen(input logic [10:0] v);
    blen_we = 1; len_wdata = v; @(negedge clk); blen_we = 0;
  endtask
  task automatic set_nblk(input logic [10:0] v);
    nblk_we = 1; len_wdata = v; @(negedge clk); nblk_we = 0;
  endtask
  task automatic start(input logic rx);
    cmd_start = 1; cmd_rx = rx; @(negedge clk); cmd_start = 0;
  endtask
  task automatic wr(input logic [15:0] d);
    cpu_wr = 1; cpu_wdata = d; @(negedge clk); cpu_wr = 0;
  endtask
  task automatic rd(output logic [15:0] d);
    cpu_rd = 1; #1 d = cpu_rdata; @(negedge clk); cpu_rd = 0;
  endtask
  task automatic send_byte(input logic [7:0] b);
    card_rx_valid = 1; card_rx_data = b; #1;
    while (!card_rx_ready) begin @(negedge clk); #1; end
    @(negedge clk); card_rx_valid = 0;
  endtask

  // transmit threshold vectors: ae[19:15] txdma[14] writes[13:8] req[7] flag[6] fill[5:0]
  localparam logic [19:0] VEC [8] = '{
    {5'd0,  1'b0, 6'd0,  1'b0, 1'b0, 6'd0},
    {5'd4,  1'b1, 6'd3,  1'b1, 1'b0, 6'd3},
    {5'd4,  1'b1, 6'd4,  1'b0, 1'b0, 6'd4},
    {5'd4,  1'b0, 6'd3,  1'b0, 1'b1, 6'd3},
    {5'd31, 1'b0, 6'd30, 1'b0, 1'b1, 6'd30},
    {5'd31, 1'b1, 6'd33, 1'b0, 1'b0, 6'd32},
    {5'd10, 1'b0, 6'd10, 1'b0, 1'b0, 6'd10},
    {5'd1,  1'b0, 6'd0,  1'b0, 1'b1, 6'd0}
  };

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual running expected finished");
    report();
  end

  initial begin
    logic [15:0] d;
    logic [7:0] got [6];
    int ng;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R6 reset state
    check("R6 status", status, 16'h0);
    check("R6 fill", fill_level, 0);
    check("R6 bytes_left", bytes_left, 1);
    check("R6 blocks_left", blocks_left, 1);
    check("R6 rx_ready", card_rx_ready, 0);
    // R6 reset almost-empty level 0: no transmit indication at fill 0
    start(0);
    check("R6 ae reset", {dma_tx_req, status[11]}, 2'b00);

    // R4 R2 threshold table
    for (int v = 0; v < 8; v++) begin
      cfg(0, 5'd31, VEC[v][14], VEC[v][19:15]);
      start(0);
      for (int k = 0; k < int'(VEC[v][13:8]); k++) wr(16'(k + 16'h100 * v));
      check($sformatf("R4 vec%0d req", v), dma_tx_req, VEC[v][7]);
      check($sformatf("R4 vec%0d flag", v), status[11], VEC[v][6]);
      check($sformatf("R2 vec%0d fill", v), fill_level, VEC[v][5:0]);
    end

    // R7 R8 R10 receive packing, odd block length 5, two blocks
    cfg(0, 5'd31, 0, 5'd0);
    set_blen(11'd4);
    check("R7 blen", bytes_left, 5);
    set_nblk(11'd1);
    check("R7 nblk", blocks_left, 2);
    check("R7 reload", bytes_left, 5);
    start(1);
    for (int i = 0; i < 5; i++) send_byte(8'h10 + 8'(i));
    check("R10 block decrement", blocks_left, 1);
    check("R10 byte reload", bytes_left, 5);
    for (int i = 5; i < 10; i++) send_byte(8'h10 + 8'(i));
    check("R10 eot", status[3], 1);
    check("R10 inactive", xfer_active, 0);
    check("R10 count reload", blocks_left, 2);
    check("R8 fill", fill_level, 6);
    check("R9 rx ready idle", card_rx_ready, 0);
    rd(d); check("R8 e0", d, 16'h1110);
    rd(d); check("R8 e1", d, 16'h1312);
    rd(d); check("R8 e2 lone", d, 16'h0014);
    rd(d); check("R8 e3", d, 16'h1615);
    rd(d); check("R8 e4", d, 16'h1817);
    rd(d); check("R8 e5 lone", d, 16'h0019);
    check("R5 idle empty", {status[11:10], dma_rx_req, dma_tx_req}, 4'b0);
    eot_clr = 1; @(negedge clk); eot_clr = 0;
    check("R10 eot clear", status[3], 0);

    // R3 R9 receive threshold and routing
    cfg(1, 5'd3, 0, 5'd0);
    set_blen(11'h7FF);
    set_nblk(11'd0);
    start(1);
    card_rx_valid = 1; card_rx_data = 8'h55;
    repeat (14) @(negedge clk);
    check("R9 rx stop fill", fill_level, 4);
    check("R9 rx ready low", card_rx_ready, 0);
    check("R3 dma req", dma_rx_req, 1);
    check("R3 flag clear", status[10], 0);
    cfg(0, 5'd3, 0, 5'd0);
    check("R3 flag set", status[10], 1);
    check("R3 dma off", dma_rx_req, 0);
    rd(d);
    check("R8 rx pair", d, 16'h5555);
    repeat (4) @(negedge clk);
    check("R9 refill", fill_level, 4);
    card_rx_valid = 0;
    start(0);
    check("R12 start clears", fill_level, 0);
    check("R12 dir latched", card_rx_ready, 0);

    // R8 R9 R10 transmit unpacking, block length 3, two blocks
    cfg(0, 5'd31, 0, 5'd0);
    set_blen(11'd2);
    set_nblk(11'd1);
    start(0);
    wr(16'hBBAA); wr(16'h00CC); wr(16'hEEDD); wr(16'h00FF);
    check("R12 fill before drain", fill_level, 4);
    ng = 0;
    card_tx_ready = 1;
    repeat (40) begin
      #1;
      if (card_tx_valid && ng < 6) begin got[ng] = card_tx_data; ng++; end
      @(negedge clk);
    end
    card_tx_ready = 0;
    check("R8 tx count", ng, 6);
    check("R8 tx b0", got[0], 8'hAA);
    check("R8 tx b1", got[1], 8'hBB);
    check("R8 tx b2 lone", got[2], 8'hCC);
    check("R8 tx b3", got[3], 8'hDD);
    check("R8 tx b5 lone", got[5], 8'hFF);
    check("R10 tx eot", status[3], 1);
    check("R9 tx valid empty", card_tx_valid, 0);

    // R11 empty read
    rd(d);
    check("R11 fill held", fill_level, 0);
    wr(16'h1234);
    rd(d);
    check("R11 pointer held", d, 16'h1234);
    check("R11 fill after", fill_level, 0);

    // R1 wrap across index 31
    for (int pass = 0; pass < 2; pass++) begin
      for (int k = 0; k < 20; k++) wr(16'(16'hA000 + 16'h40 * pass + k));
      for (int k = 0; k < 20; k++) begin
        rd(d);
        check($sformatf("R1 wrap p%0d k%0d", pass, k), d, 16'(16'hA000 + 16'h40 * pass + k));
      end
    end
    report();
  end
endmodule